// File: doc/BRIEF.md
# Banked Memory Controller with Latched Time Registers

This block sits between a CPU's 16-bit address bus and a cartridge-style memory system. It decodes CPU writes into its control registers and turns each access into a physical ROM address, a physical RAM address, or a data byte that it supplies itself. The lower ROM window always maps to the first 16 KiB of ROM. The upper ROM window maps to a switchable 16 KiB bank chosen by a 7-bit bank register. The 8 KiB data window at 0xA000-0xBFFF serves one of two sources. It can show one of four external RAM banks, or one of five time registers (seconds, minutes, hours, day low, day high).

One select register both picks the RAM bank and decides whether the data window shows RAM or a time register. The time registers are frozen copies of live counter values supplied on an input port. A two-write sequence to the latch region takes a fresh copy. Data-window writes that target a time register go to a write-back register set on an output port. The oscillator, the counters themselves and the RAM array all lie outside the block.

Top module: `bank_timer_ctl`

## Requirements
- R1: A write in 0x0000-0x1FFF enables data-window access when data bits [3:0] equal 0xA and disables it for any other value. Reset leaves access disabled.
- R2: A write in 0x2000-0x3FFF loads the ROM bank from data bits [6:0]. If those seven bits are zero, the bank becomes 1. Data bit 7 is ignored.
- R3: rom_addr_o equals bus_addr_i[13:0] for addresses 0x0000-0x3FFF. For 0x4000-0x7FFF it equals ROM bank × 0x4000 + bus_addr_i[13:0].
- R4: A write of 0x00-0x03 in 0x4000-0x5FFF sets the RAM bank to that value and maps RAM into the data window.
- R5: A write of 0x08-0x0C in 0x4000-0x5FFF maps time register (value − 0x08) into the data window (0 seconds, 1 minutes, 2 hours, 3 day low, 4 day high). Any other value in that region changes neither the mapping nor the RAM bank.
- R6: Each write in 0x6000-0x7FFF is remembered. A write of 0x01 whose remembered predecessor is 0x00 copies live_time_i (byte k = register k) into the latched time registers at that clock edge. No other sequence latches, and after reset nothing is remembered.
- R7: When access is enabled and RAM is mapped, an access in 0xA000-0xBFFF raises ram_sel_o with ram_addr_o = RAM bank × 0x2000 + bus_addr_i[12:0]. ram_we_o follows bus_wr_i during such an access.
- R8: With access disabled or nothing mapped, a data-window access gives win_rdata_valid_o = 1 and win_rdata_o = 0xFF. A write in that case leaves ram_we_o low and time_wb_o unchanged.
- R9: With access enabled and a time register mapped, a data-window read returns that register's latched byte. A write stores the data into the matching byte of time_wb_o (byte k at bits 8k+7:8k).
- R10: After reset the ROM bank is 1, the RAM bank is 0, nothing is mapped, access is disabled, and all latched and write-back time bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 16 | CPU address |
| bus_wr_i | input | 1 | Write strobe; low means read |
| bus_wdata_i | input | 8 | CPU write data |
| live_time_i | input | 40 | Live time counters, byte k = register k |
| rom_addr_o | output | 21 | Physical ROM address |
| ram_addr_o | output | 15 | Physical RAM address |
| ram_sel_o | output | 1 | Data-window access goes to external RAM |
| ram_we_o | output | 1 | Write enable to external RAM |
| win_rdata_o | output | 8 | Byte supplied by the block for the data window |
| win_rdata_valid_o | output | 1 | win_rdata_o is the data-window read value |
| time_wb_o | output | 40 | Write-back time registers, byte k = register k |

## Verification
The assertions check, on every cycle, the invariants that tie state to outputs: the ROM bank is never zero, a RAM write strobe needs RAM selection, a disabled window reads 0xFF, rejected select values leave the mapping alone, and a latch pulse copies the live counters at that edge. Only the bench's scenarios can show the full mappings. It sweeps all 256 data values through the enable, ROM bank and select registers and checks the resulting addresses arithmetically. It also checks which write orderings in the latch region capture the clock and which do not, and whether write-back bytes land in the right slot.

// File: rtl/bank_timer_pkg.sv
package bank_timer_pkg;

    localparam int ROM_BANK_W = 7;
    localparam int RAM_BANK_W = 2;
    localparam int TIME_IDX_W = 3;

    typedef enum logic [1:0] {
        MAP_NONE = 2'd0,
        MAP_RAM  = 2'd1,
        MAP_TIME = 2'd2
    } win_map_e;

    typedef struct packed {
        logic                  enabled;
        win_map_e              map;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [TIME_IDX_W-1:0] time_idx;
    } ctl_state_t;

    typedef struct packed {
        logic rom_hi;
        logic wr_enable;
        logic wr_rom;
        logic wr_sel;
        logic wr_latch;
        logic window;
    } region_t;

endpackage

// File: rtl/bank_timer_region_dec.sv
module bank_timer_region_dec
    import bank_timer_pkg::*;
(
    input  logic [2:0] addr_top_i,
    output region_t    region_o
);

    always_comb begin
        region_o           = '0;
        region_o.rom_hi    = (addr_top_i[2:1] == 2'b01);
        region_o.wr_enable = (addr_top_i == 3'b000);
        region_o.wr_rom    = (addr_top_i == 3'b001);
        region_o.wr_sel    = (addr_top_i == 3'b010);
        region_o.wr_latch  = (addr_top_i == 3'b011);
        region_o.window    = (addr_top_i == 3'b101);
    end

    always_comb begin
        assert_regions_exclusive_R1: assert ($onehot0({region_o.wr_enable, region_o.wr_rom,
            region_o.wr_sel, region_o.wr_latch, region_o.window}))
            else $error("write regions overlap");
    end

endmodule

// File: rtl/bank_timer_latch_seq.sv
module bank_timer_latch_seq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              fire_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] value;
    } memo_t;

    memo_t memo_d, memo_q;

    always_comb begin
        memo_d = memo_q;
        fire_o = 1'b0;
        if (wr_stb_i) begin
            fire_o = memo_q.valid && (memo_q.value == '0) && (wdata_i == DATA_W'(1));
            memo_d.valid = 1'b1;
            memo_d.value = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) memo_q <= '0;
        else        memo_q <= memo_d;
    end

    property p_memo_after_fire;
        @(posedge clk) disable iff (!rst_n)
        fire_o |=> (memo_q.valid && memo_q.value == DATA_W'(1));
    endproperty
    assert_latch_memo_R6: assert property (p_memo_after_fire)
        else $error("latch memo not updated after fire");

endmodule

// File: rtl/bank_timer_time_regs.sv
module bank_timer_time_regs #(
    parameter int N_REGS = 5,
    parameter int REG_W  = 8,
    parameter int IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    latch_i,
    input  logic [N_REGS*REG_W-1:0] live_i,
    input  logic                    wb_stb_i,
    input  logic [IDX_W-1:0]        wb_idx_i,
    input  logic [REG_W-1:0]        wb_data_i,
    output logic [N_REGS*REG_W-1:0] latched_o,
    output logic [N_REGS*REG_W-1:0] wb_o
);

    logic [N_REGS-1:0][REG_W-1:0] lat_d, lat_q, wb_d, wb_q, live_w;

    assign live_w    = live_i;
    assign latched_o = lat_q;
    assign wb_o      = wb_q;

    for (genvar k = 0; k < N_REGS; k++) begin : g_slot
        always_comb begin
            lat_d[k] = latch_i ? live_w[k] : lat_q[k];
            wb_d[k]  = (wb_stb_i && wb_idx_i == IDX_W'(k)) ? wb_data_i : wb_q[k];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q[k] <= '0;
                wb_q[k]  <= '0;
            end else begin
                lat_q[k] <= lat_d[k];
                wb_q[k]  <= wb_d[k];
            end
        end
    end

    property p_latch_copies;
        @(posedge clk) disable iff (!rst_n)
        latch_i |=> (latched_o == $past(live_i));
    endproperty
    assert_latch_copies_R6: assert property (p_latch_copies)
        else $error("latched registers differ from live values");

    property p_wb_hold;
        @(posedge clk) disable iff (!rst_n)
        !wb_stb_i |=> $stable(wb_o);
    endproperty
    assert_wb_hold_R8: assert property (p_wb_hold)
        else $error("write-back changed without a strobe");

endmodule

// File: rtl/bank_timer_ctl.sv
module bank_timer_ctl
    import bank_timer_pkg::*;
#(
    parameter int NUM_TIME_REGS = 5,
    parameter int TIME_BASE     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [15:0]                   bus_addr_i,
    input  logic                          bus_wr_i,
    input  logic [7:0]                    bus_wdata_i,
    input  logic [NUM_TIME_REGS*8-1:0]    live_time_i,
    output logic [ROM_BANK_W+13:0]        rom_addr_o,
    output logic [RAM_BANK_W+12:0]        ram_addr_o,
    output logic                          ram_sel_o,
    output logic                          ram_we_o,
    output logic [7:0]                    win_rdata_o,
    output logic                          win_rdata_valid_o,
    output logic [NUM_TIME_REGS*8-1:0]    time_wb_o
);

    localparam int RAM_BANKS = 1 << RAM_BANK_W;
    localparam int TIME_TOP  = TIME_BASE + NUM_TIME_REGS;

    ctl_state_t st_d, st_q;
    region_t    region;
    logic       latch_fire;
    logic       wb_stb;
    logic [NUM_TIME_REGS*8-1:0]      latched_flat;
    logic [NUM_TIME_REGS-1:0][7:0]   latched_w;
    logic [7:0]                      time_byte;

    bank_timer_region_dec u_dec (
        .addr_top_i (bus_addr_i[15:13]),
        .region_o   (region)
    );

    bank_timer_latch_seq #(.DATA_W(8)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (bus_wr_i && region.wr_latch),
        .wdata_i  (bus_wdata_i),
        .fire_o   (latch_fire)
    );

    assign wb_stb = bus_wr_i && region.window && st_q.enabled && (st_q.map == MAP_TIME);

    bank_timer_time_regs #(
        .N_REGS (NUM_TIME_REGS),
        .REG_W  (8),
        .IDX_W  (TIME_IDX_W)
    ) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_i   (latch_fire),
        .live_i    (live_time_i),
        .wb_stb_i  (wb_stb),
        .wb_idx_i  (st_q.time_idx),
        .wb_data_i (bus_wdata_i),
        .latched_o (latched_flat),
        .wb_o      (time_wb_o)
    );

    assign latched_w = latched_flat;

    // next-state computation for the control registers
    always_comb begin
        st_d = st_q;
        if (bus_wr_i) begin
            if (region.wr_enable) begin
                st_d.enabled = (bus_wdata_i[3:0] == 4'hA);
            end
            if (region.wr_rom) begin
                st_d.rom_bank = (bus_wdata_i[ROM_BANK_W-1:0] == '0)
                              ? ROM_BANK_W'(1) : bus_wdata_i[ROM_BANK_W-1:0];
            end
            if (region.wr_sel) begin
                if (bus_wdata_i < 8'(RAM_BANKS)) begin
                    st_d.ram_bank = bus_wdata_i[RAM_BANK_W-1:0];
                    st_d.map      = MAP_RAM;
                end else if (bus_wdata_i >= 8'(TIME_BASE) && bus_wdata_i < 8'(TIME_TOP)) begin
                    st_d.time_idx = TIME_IDX_W'(bus_wdata_i - 8'(TIME_BASE));
                    st_d.map      = MAP_TIME;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.map      <= MAP_NONE;
            st_q.rom_bank <= ROM_BANK_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    // selected latched byte
    always_comb begin
        time_byte = 8'hFF;
        for (int k = 0; k < NUM_TIME_REGS; k++) begin
            if (st_q.time_idx == TIME_IDX_W'(k)) time_byte = latched_w[k];
        end
    end

    // address and data outputs
    always_comb begin
        rom_addr_o = region.rom_hi ? {st_q.rom_bank, bus_addr_i[13:0]}
                                   : {{ROM_BANK_W{1'b0}}, bus_addr_i[13:0]};
        ram_addr_o        = {st_q.ram_bank, bus_addr_i[12:0]};
        ram_sel_o         = region.window && st_q.enabled && (st_q.map == MAP_RAM);
        ram_we_o          = ram_sel_o && bus_wr_i;
        win_rdata_valid_o = region.window && !ram_sel_o;
        win_rdata_o       = (st_q.enabled && st_q.map == MAP_TIME) ? time_byte : 8'hFF;
    end

    property p_bank_nonzero;
        @(posedge clk) disable iff (!rst_n)
        st_q.rom_bank != '0;
    endproperty
    assert_bank_nonzero_R2: assert property (p_bank_nonzero)
        else $error("ROM bank register holds zero");

    property p_enable_set;
        @(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i[15:13] == 3'b000 && bus_wdata_i[3:0] == 4'hA) |=> st_q.enabled;
    endproperty
    assert_enable_set_R1: assert property (p_enable_set)
        else $error("enable write did not enable access");

    property p_sel_ignore;
        @(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i[15:13] == 3'b010 && bus_wdata_i >= 8'(RAM_BANKS)
            && (bus_wdata_i < 8'(TIME_BASE) || bus_wdata_i >= 8'(TIME_TOP)))
        |=> ($stable(st_q.map) && $stable(st_q.ram_bank) && $stable(st_q.time_idx));
    endproperty
    assert_sel_ignore_R5: assert property (p_sel_ignore)
        else $error("rejected select value changed the mapping");

    property p_we_needs_sel;
        @(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_sel_o && bus_wr_i && bus_addr_i[15:13] == 3'b101);
    endproperty
    assert_we_needs_sel_R7: assert property (p_we_needs_sel)
        else $error("RAM write strobe outside a selected RAM access");

    property p_disabled_ff;
        @(posedge clk) disable iff (!rst_n)
        (win_rdata_valid_o && !st_q.enabled) |-> (win_rdata_o == 8'hFF);
    endproperty
    assert_disabled_ff_R8: assert property (p_disabled_ff)
        else $error("disabled window did not read 0xFF");

endmodule

// File: tb/bank_timer_ctl_bench.sv
module bank_timer_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr_i = 16'h0000;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_wdata_i = 8'h00;
    logic [39:0] live_time_i = 40'h0;
    logic [20:0] rom_addr_o;
    logic [14:0] ram_addr_o;
    logic        ram_sel_o, ram_we_o, win_rdata_valid_o;
    logic [7:0]  win_rdata_o;
    logic [39:0] time_wb_o;

    int vectors = 0;
    int fails   = 0;

    // reference model
    logic [6:0]  m_rom = 7'd1;
    logic [1:0]  m_ram = 2'd0;
    int          m_map = 0;      // 0 none, 1 ram, 2 time
    int          m_idx = 0;
    logic        m_en  = 1'b0;
    logic        m_pv  = 1'b0;
    logic [7:0]  m_prev = 8'h00;
    logic [39:0] m_lat = 40'h0;
    logic [39:0] m_wb  = 40'h0;

    always #5 clk = ~clk;

    bank_timer_ctl u_bank_timer_ctl (
        .clk               (clk),
        .rst_n             (rst_n),
        .bus_addr_i        (bus_addr_i),
        .bus_wr_i          (bus_wr_i),
        .bus_wdata_i       (bus_wdata_i),
        .live_time_i       (live_time_i),
        .rom_addr_o        (rom_addr_o),
        .ram_addr_o        (ram_addr_o),
        .ram_sel_o         (ram_sel_o),
        .ram_we_o          (ram_we_o),
        .win_rdata_o       (win_rdata_o),
        .win_rdata_valid_o (win_rdata_valid_o),
        .time_wb_o         (time_wb_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        case (a[15:13])
            3'b000: m_en = (d[3:0] == 4'hA);
            3'b001: m_rom = (d[6:0] == 7'd0) ? 7'd1 : d[6:0];
            3'b010: begin
                if (d <= 8'h03) begin m_ram = d[1:0]; m_map = 1; end
                else if (d >= 8'h08 && d <= 8'h0C) begin m_map = 2; m_idx = int'(d) - 8; end
            end
            3'b011: begin
                if (d == 8'h01 && m_pv && m_prev == 8'h00) m_lat = live_time_i;
                m_pv = 1'b1; m_prev = d;
            end
            3'b101: if (m_en && m_map == 2) m_wb[m_idx*8 +: 8] = d;
            default: ;
        endcase
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        #1;
        if (a[15:13] == 3'b101)
            chk(ram_we_o == (m_en && m_map == 1), "R7/R8 ram_we", ram_we_o, (m_en && m_map == 1));
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a);
        logic [20:0] er;
        logic        esel;
        logic [7:0]  ed;
        @(negedge clk);
        bus_addr_i = a; bus_wr_i = 1'b0;
        #1;
        if (a < 16'h8000) begin
            er = a[14] ? {m_rom, a[13:0]} : {7'd0, a[13:0]};
            chk(rom_addr_o == er, "R3 rom_addr", rom_addr_o, er);
        end
        if (a[15:13] == 3'b101) begin
            esel = m_en && m_map == 1;
            chk(ram_sel_o == esel, "R1/R4 ram_sel", ram_sel_o, esel);
            if (esel) begin
                chk(ram_addr_o == {m_ram, a[12:0]}, "R7 ram_addr", ram_addr_o, {m_ram, a[12:0]});
            end else begin
                ed = (m_en && m_map == 2) ? m_lat[m_idx*8 +: 8] : 8'hFF;
                chk(win_rdata_valid_o && win_rdata_o == ed, "R8/R9 win_rdata", win_rdata_o, ed);
            end
        end
        chk(time_wb_o == m_wb, "R9 time_wb", time_wb_o, m_wb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        live_time_i = 40'h15_04_17_2A_3B;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        do_rd(16'h4000);
        do_rd(16'hA000);
        chk(time_wb_o == 40'h0, "R10 wb reset", time_wb_o, 0);
        do_wr(16'h0000, 8'h0A);
        do_rd(16'hA010);                 // enabled but nothing mapped: 0xFF
        do_wr(16'h4000, 8'h08);
        do_rd(16'hA000);                 // R10 latched seconds are zero
        do_wr(16'h6000, 8'h01);          // R6: lone 0x01 after reset, no latch
        do_rd(16'hA000);

        // R2/R3: all ROM bank values
        for (int d = 0; d < 256; d++) begin
            do_wr(16'h2000 + 16'(d * 31), 8'(d));
            do_rd(16'h4000);
            do_rd(16'h7FFF);
            do_rd(16'h1234 + 16'(d));
        end

        // R1: all enable values, RAM mapped
        do_wr(16'h4000, 8'h02);
        for (int d = 0; d < 256; d++) begin
            do_wr(16'h1FFF - 16'(d), 8'(d));
            do_rd(16'hA123);
            do_wr(16'hBF00, 8'(d));
        end

        // R4/R5/R7/R9: all select values, access enabled
        do_wr(16'h0100, 8'hFA);
        for (int d = 0; d < 256; d++) begin
            do_wr(16'h5000, 8'(d));
            do_rd(16'hA123);
            do_rd(16'hBFFF);
        end

        // R6: latch sequences
        live_time_i = 40'h01_C8_0B_1E_2D;
        do_wr(16'h6000, 8'h00);
        do_wr(16'h6001, 8'h02);
        do_wr(16'h6002, 8'h01);          // broken sequence, no latch
        do_wr(16'h6000, 8'h00);
        do_wr(16'h2000, 8'h05);          // other regions do not disturb memo
        do_wr(16'h7FFF, 8'h01);          // latch
        live_time_i = 40'h00_11_22_33_44;
        for (int k = 0; k < 5; k++) begin
            do_wr(16'h4000, 8'(8 + k));
            do_rd(16'hA000 + 16'(k));
        end
        do_wr(16'h6000, 8'h01);          // 0x01 after 0x01: no latch
        do_rd(16'hA000);

        // R9: write-back per slot, then R8: disabled writes ignored
        for (int k = 0; k < 5; k++) begin
            do_wr(16'h4000, 8'(8 + k));
            do_wr(16'hA800, 8'(8'h50 + k));
            do_rd(16'hA800);
        end
        do_wr(16'h0000, 8'h00);
        do_wr(16'h4000, 8'h0A);
        do_wr(16'hA000, 8'hEE);
        do_rd(16'hA000);
        do_wr(16'h4000, 8'h01);
        do_wr(16'hA000, 8'hDD);
        do_rd(16'hA000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule